// File: doc/BRIEF.md
# Interference-Driven Source Throttle Controller

This block sits beside the request sources of a multi-core chip and decides, once per fixed interval, how hard each core is held back. During the interval it counts two things for every core. The first is the cycles that core spends running in shared mode. The second is, for every ordered pair of cores, the cycles in which one core was delayed by another. Detection of those delays happens elsewhere, in the cache and memory logic, and arrives here as one event bit per pair.

At the end of the interval the block estimates each core's weighted slowdown. It then forms the ratio of the largest slowdown to the smallest and compares it with a target set by software. When the target is exceeded, the core that delays the slowest core the most is throttled one level harder, and the slowest core is released by one level.

Each core has a throttle level from 0 (full rate) to 6 (harshest). The level maps onto two controls: a quota of outstanding miss-buffer entries out of 128, and an injection-enable pulse that repeats at a level-dependent period. All ratio comparisons use cross-multiplication, so the block has no divider.

The controller is a four-state machine:
- ACCUM counts events for INTERVAL cycles and then moves to SCAN.
- SCAN visits one core per cycle to find the highest and lowest weighted slowdown, and moves to HUNT after the last core.
- HUNT visits one candidate per cycle to find the main interferer of the slowest core, and moves to JUDGE after the last candidate.
- JUDGE compares against the target, applies the level moves, clears all counters, restarts the injection phases and returns to ACCUM.

Top module: `src_throttle_ctrl`

## Requirements
- R1: While reset is asserted, and after it is asserted in the middle of a run, every core is at level 0: the quota reads 128 and the injection enable is high in every cycle.
- R2: Levels 0 to 6 give the quotas 128, 64, 32, 12, 6, 5 and 3.
- R3: Levels 0 to 6 give injection periods of 1, 2, 4, 10, 25, 30 and 33 cycles. Every core's injection phase restarts at each interval boundary, so the first cycle of an interval is an injection slot and an interval of L cycles holds ceil(L/period) pulses.
- R4: The excess of core i is the sum over j of the pair count "core j delayed core i". Pair events sit on bit i*NCORE+j of `intf_evt_i`, and the diagonal bits are ignored. The slowdown of core i is weight*S/(S-E), where S is its shared-cycle count and E its excess. A core with S=0 counts as 1/1, and a core with E>=S has a denominator of 1.
- R5: The target is unsigned with four fraction bits (16 means 1.0). Levels move only when max slowdown / min slowdown is strictly greater than the target. Equality causes no move.
- R6: On a move, the interfering core is the one with the largest nonzero pair count against the slowest core. The interferer goes one level up and the slowest core goes one level down. Ties for slowest, smallest and interferer go to the lowest core index.
- R7: When the slowest core has no nonzero pair count against it, no level changes, even when the unfairness exceeds the target.
- R8: The per-core weight multiplies that core's slowdown before both the max/min search and the unfairness ratio, so a larger weight can make a core the slowest.
- R9: Levels saturate: a core at level 0 is not released further, and a core at level 6 is not throttled further.
- R10: Events are counted only during the INTERVAL accumulation cycles, and events during the 2*NCORE+1 evaluation cycles are ignored. New levels and quotas appear at the end of the last evaluation cycle, and all counters restart from zero for the next interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_cyc_i | input | NCORE | Per-core flag: this cycle counts as a shared-mode cycle |
| intf_evt_i | input | NCORE*NCORE | Bit i*NCORE+j: core j delayed core i this cycle |
| weight_i | input | NCORE*WW | Per-core slowdown weight, core c at bits c*WW |
| target_i | input | TW | Unfairness target, TFRAC fraction bits |
| quota_o | output | NCORE*8 | Per-core outstanding-entry quota, core c at bits c*8 |
| inj_en_o | output | NCORE | Per-core injection-enable pulse |

## Verification
A wrong internal state is visible at the ports at the end of the interval in which it arises. A bad slowdown, a bad max/min choice or a bad interferer choice moves the wrong core's quota, or fails to move it, at the JUDGE edge. A counter that is not cleared, or that counts during evaluation, shows up one interval later as a move that should not happen. A wrong period or a missed phase restart changes the number of enable pulses within the very next interval. Level saturation errors show as a quota leaving the seven legal values, or stepping past 128 or 3.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;

    localparam int LVL_W   = 3;
    localparam int LVL_TOP = 6;
    localparam int QUOTA_W = 8;
    localparam int PER_W   = 6;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_SCAN  = 2'd1,
        ST_HUNT  = 2'd2,
        ST_JUDGE = 2'd3
    } stc_state_e;

    // Outstanding-entry allowance for each throttle level
    function automatic logic [QUOTA_W-1:0] lvl_quota(input lvl_t l);
        logic [QUOTA_W-1:0] q;
        case (l)
            3'd0:    q = 8'd128;
            3'd1:    q = 8'd64;
            3'd2:    q = 8'd32;
            3'd3:    q = 8'd12;
            3'd4:    q = 8'd6;
            3'd5:    q = 8'd5;
            default: q = 8'd3;
        endcase
        return q;
    endfunction

    // Cycles between injection slots for each throttle level
    function automatic logic [PER_W-1:0] lvl_period(input lvl_t l);
        logic [PER_W-1:0] p;
        case (l)
            3'd0:    p = 6'd1;
            3'd1:    p = 6'd2;
            3'd2:    p = 6'd4;
            3'd3:    p = 6'd10;
            3'd4:    p = 6'd25;
            3'd5:    p = 6'd30;
            default: p = 6'd33;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/stc_counters.sv
`timescale 1ns/1ps
module stc_counters #(
    parameter int NCORE = 4,
    parameter int CW    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_en,
    input  logic                        clr,
    input  logic [NCORE-1:0]            shared_i,
    input  logic [NCORE*NCORE-1:0]      evt_i,
    output logic [NCORE*CW-1:0]         shared_cnt_o,
    output logic [NCORE*CW-1:0]         excess_o,
    output logic [NCORE*NCORE*CW-1:0]   pair_o
);
    localparam int SUMW = CW + $clog2(NCORE);

    genvar gi, gj;
    for (gi = 0; gi < NCORE; gi++) begin : g_row
        logic [CW-1:0]   sh_q;
        logic [SUMW-1:0] sum;

        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                sh_q <= '0;
            else if (cnt_en && shared_i[gi] && sh_q != '1)
                sh_q <= sh_q + CW'(1);
        end
        assign shared_cnt_o[gi*CW +: CW] = sh_q;

        for (gj = 0; gj < NCORE; gj++) begin : g_col
            if (gi != gj) begin : g_cnt
                logic [CW-1:0] c_q;
                always_ff @(posedge clk) begin
                    if (!rst_n || clr)
                        c_q <= '0;
                    else if (cnt_en && evt_i[gi*NCORE+gj] && c_q != '1)
                        c_q <= c_q + CW'(1);
                end
                assign pair_o[(gi*NCORE+gj)*CW +: CW] = c_q;
            end else begin : g_diag
                assign pair_o[(gi*NCORE+gj)*CW +: CW] = '0;
            end
        end

        always_comb begin
            sum = '0;
            for (int j = 0; j < NCORE; j++)
                sum = sum + SUMW'(pair_o[(gi*NCORE+j)*CW +: CW]);
        end
        assign excess_o[gi*CW +: CW] = (sum > SUMW'({CW{1'b1}})) ? {CW{1'b1}} : sum[CW-1:0];
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clr) |=> ($stable(shared_cnt_o) && $stable(pair_o)));

    // R10
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (shared_cnt_o == '0 && excess_o == '0));

endmodule

// File: rtl/stc_pacer.sv
`timescale 1ns/1ps
module stc_pacer
    import stc_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart_i,
    input  logic [NCORE*LVL_W-1:0] lvl_i,
    output logic [NCORE-1:0]       inj_o
);
    genvar g;
    for (g = 0; g < NCORE; g++) begin : g_core
        logic [PER_W-1:0] ph_q;
        logic [PER_W-1:0] per;

        assign per = lvl_period(lvl_i[g*LVL_W +: LVL_W]);

        always_ff @(posedge clk) begin
            if (!rst_n || restart_i)
                ph_q <= '0;
            else if (ph_q == '0)
                ph_q <= per - PER_W'(1);
            else
                ph_q <= ph_q - PER_W'(1);
        end

        assign inj_o[g] = (ph_q == '0);

        // R3
        slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inj_o[g] && !restart_i && per != PER_W'(1)) |=> !inj_o[g]);

        // R3
        restart_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            restart_i |=> inj_o[g]);
    end
endmodule

// File: rtl/src_throttle_ctrl.sv
`timescale 1ns/1ps
module src_throttle_ctrl
    import stc_pkg::*;
#(
    parameter int NCORE    = 4,
    parameter int CW       = 16,
    parameter int WW       = 4,
    parameter int TW       = 8,
    parameter int TFRAC    = 4,
    parameter int INTERVAL = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORE-1:0]         shared_cyc_i,
    input  logic [NCORE*NCORE-1:0]   intf_evt_i,
    input  logic [NCORE*WW-1:0]      weight_i,
    input  logic [TW-1:0]            target_i,
    output logic [NCORE*QUOTA_W-1:0] quota_o,
    output logic [NCORE-1:0]         inj_en_o
);
    localparam int IDXW = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int ICW  = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int NUMW = CW + WW;
    localparam int PW   = NUMW + CW;
    localparam int JW   = NUMW + CW + TW + TFRAC;
    localparam logic [ICW-1:0]  IC_LAST  = ICW'(INTERVAL - 1);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NCORE - 1);

    stc_state_e state_q, state_d;

    logic [ICW-1:0]             ic_q;
    logic [IDXW-1:0]            idx_q;
    logic [NUMW-1:0]            max_num_q, min_num_q;
    logic [CW-1:0]              max_den_q, min_den_q;
    logic [IDXW-1:0]            max_idx_q, intf_q;
    logic [CW-1:0]              best_q;
    logic                       found_q;
    logic [NCORE-1:0][LVL_W-1:0] lvl_q;
    logic [NCORE*LVL_W-1:0]     lvl_flat;

    logic [NCORE*CW-1:0]        shared_cnt, excess;
    logic [NCORE*NCORE*CW-1:0]  pair_cnt;

    logic [CW-1:0]   s_cur, e_cur, num_cur, den_cur, pair_cur;
    logic [WW-1:0]   w_cur;
    logic [NUMW-1:0] wnum_cur;
    logic            gt_max, lt_min, unfair, apply, last_idx;

    stc_counters #(.NCORE(NCORE), .CW(CW)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_en       (state_q == ST_ACCUM),
        .clr          (state_q == ST_JUDGE),
        .shared_i     (shared_cyc_i),
        .evt_i        (intf_evt_i),
        .shared_cnt_o (shared_cnt),
        .excess_o     (excess),
        .pair_o       (pair_cnt)
    );

    // Slowdown terms for the core visited this cycle
    always_comb begin
        s_cur    = shared_cnt[int'(idx_q)*CW +: CW];
        e_cur    = excess[int'(idx_q)*CW +: CW];
        w_cur    = weight_i[int'(idx_q)*WW +: WW];
        num_cur  = (s_cur == '0) ? CW'(1) : s_cur;
        den_cur  = (s_cur > e_cur) ? (s_cur - e_cur) : CW'(1);
        wnum_cur = NUMW'(w_cur) * NUMW'(num_cur);
        gt_max   = (PW'(wnum_cur) * PW'(max_den_q)) > (PW'(max_num_q) * PW'(den_cur));
        lt_min   = (PW'(wnum_cur) * PW'(min_den_q)) < (PW'(min_num_q) * PW'(den_cur));
        pair_cur = pair_cnt[(int'(max_idx_q)*NCORE + int'(idx_q))*CW +: CW];
        unfair   = (JW'(max_num_q) * JW'(min_den_q) * JW'(2**TFRAC)) >
                   (JW'(target_i) * JW'(max_den_q) * JW'(min_num_q));
        apply    = unfair && found_q;
        last_idx = (idx_q == IDX_LAST);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM: if (ic_q == IC_LAST) state_d = ST_SCAN;
            ST_SCAN:  if (last_idx)        state_d = ST_HUNT;
            ST_HUNT:  if (last_idx)        state_d = ST_JUDGE;
            ST_JUDGE:                      state_d = ST_ACCUM;
            default:                       state_d = ST_ACCUM;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACCUM;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ic_q      <= '0;
            idx_q     <= '0;
            max_num_q <= '0;
            max_den_q <= CW'(1);
            max_idx_q <= '0;
            min_num_q <= '0;
            min_den_q <= CW'(1);
            best_q    <= '0;
            intf_q    <= '0;
            found_q   <= 1'b0;
            lvl_q     <= '0;
        end else begin
            unique case (state_q)
                ST_ACCUM: begin
                    ic_q  <= (ic_q == IC_LAST) ? '0 : ic_q + ICW'(1);
                    idx_q <= '0;
                end
                ST_SCAN: begin
                    if (idx_q == '0 || gt_max) begin
                        max_num_q <= wnum_cur;
                        max_den_q <= den_cur;
                        max_idx_q <= idx_q;
                    end
                    if (idx_q == '0 || lt_min) begin
                        min_num_q <= wnum_cur;
                        min_den_q <= den_cur;
                    end
                    best_q  <= '0;
                    found_q <= 1'b0;
                    idx_q   <= last_idx ? '0 : idx_q + IDXW'(1);
                end
                ST_HUNT: begin
                    if (idx_q != max_idx_q && pair_cur > best_q) begin
                        best_q  <= pair_cur;
                        intf_q  <= idx_q;
                        found_q <= 1'b1;
                    end
                    idx_q <= last_idx ? '0 : idx_q + IDXW'(1);
                end
                ST_JUDGE: begin
                    if (apply) begin
                        if (lvl_q[intf_q] != LVL_W'(LVL_TOP))
                            lvl_q[intf_q] <= lvl_q[intf_q] + LVL_W'(1);
                        if (lvl_q[max_idx_q] != '0)
                            lvl_q[max_idx_q] <= lvl_q[max_idx_q] - LVL_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    assign lvl_flat = lvl_q;

    genvar g;
    for (g = 0; g < NCORE; g++) begin : g_out
        assign quota_o[g*QUOTA_W +: QUOTA_W] = lvl_quota(lvl_q[g]);

        // R9
        lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_q[g] <= LVL_W'(LVL_TOP));
    end

    stc_pacer #(.NCORE(NCORE)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state_q == ST_JUDGE),
        .lvl_i     (lvl_flat),
        .inj_o     (inj_en_o)
    );

    // R6
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_JUDGE) |=> $stable(lvl_q));

    // R7
    no_interferer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && !found_q) |=> $stable(lvl_q));

    // R10
    judge_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |=> (state_q == ST_ACCUM && ic_q == '0));

    // R10
    accum_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUM && ic_q != IC_LAST) |=> (state_q == ST_ACCUM));

endmodule

// File: tb/src_throttle_ctrl_test.sv
`timescale 1ns/1ps
module src_throttle_ctrl_test;
    localparam int NC   = 4;
    localparam int WW   = 4;
    localparam int TW   = 8;
    localparam int INTV = 100;
    localparam int EVAL = 2*NC + 1;
    localparam int VEC_N = 16;

    // victim1, aggressor1, events1, victim2, aggressor2, events2, weight of core2,
    // target, quotas core0..3 after the round, pulses core0..3 during the round
    localparam int TBL [VEC_N][16] = '{
        '{1,2,50, 0,0,0, 1,24,  128,128,64,128,  100,100,100,100},
        '{1,2,50, 0,0,0, 1,24,  128,128,32,128,  100,100,50,100},
        '{1,2,50, 0,0,0, 1,32,  128,128,32,128,  100,100,25,100},
        '{1,2,20, 0,0,0, 1,24,  128,128,32,128,  100,100,25,100},
        '{0,0,0,  0,0,0, 1,8,   128,128,32,128,  100,100,25,100},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,64,   100,100,25,100},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,32,   100,100,25,50},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,12,   100,100,25,25},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,6,    100,100,25,10},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,5,    100,100,25,4},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,3,    100,100,25,4},
        '{0,3,50, 0,0,0, 1,24,  128,128,32,3,    100,100,25,4},
        '{3,2,50, 0,0,0, 1,24,  128,128,12,5,    100,100,25,4},
        '{1,0,40, 2,3,30, 1,24, 64,128,12,5,     100,100,10,4},
        '{1,0,40, 2,3,30, 2,24, 64,128,32,3,     50,100,10,4},
        '{0,0,0,  0,0,0, 1,255, 64,128,32,3,     50,100,25,4}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        shared = '0;
    logic [NC*NC-1:0]     evt = '0;
    logic [NC*WW-1:0]     wgt = '0;
    logic [TW-1:0]        tgt = '0;
    logic [NC*8-1:0]      quota;
    logic [NC-1:0]        inj;

    int checks = 0;
    int errors = 0;
    int pc [NC];

    always #2.5 clk = ~clk;

    src_throttle_ctrl #(.NCORE(NC), .CW(16), .WW(WW), .TW(TW), .TFRAC(4), .INTERVAL(INTV)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .shared_cyc_i (shared),
        .intf_evt_i   (evt),
        .weight_i     (wgt),
        .target_i     (tgt),
        .quota_o      (quota),
        .inj_en_o     (inj)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int q_of(input int c);
        return int'(quota[c*8 +: 8]);
    endfunction

    function automatic string row_tag(input int r);
        case (r)
            0, 1:         return "R6";
            2, 3:         return "R5";
            4:            return "R7";
            5, 10, 11:    return "R9";
            6, 7, 8, 9:   return "R2";
            12, 13:       return "R4";
            14:           return "R8";
            default:      return "R3";
        endcase
    endfunction

    // One full interval plus its evaluation; ends just after the judge edge
    task automatic run_round(input int v1, a1, e1, v2, a2, e2, w2, t,
                             input bit eval_noise, input bit mid_chk);
        for (int c = 0; c < NC; c++) begin
            wgt[c*WW +: WW] = (c == 2) ? WW'(w2) : WW'(1);
            pc[c] = 0;
        end
        tgt = TW'(t);
        for (int c = 0; c < INTV; c++) begin
            shared = '1;
            evt    = '0;
            if (v1 != a1 && c < e1) evt[v1*NC+a1] = 1'b1;
            if (v2 != a2 && c < e2) evt[v2*NC+a2] = 1'b1;
            for (int k = 0; k < NC; k++)
                if (inj[k]) pc[k]++;
            @(negedge clk);
        end
        shared = eval_noise ? '1 : '0;
        evt    = '0;
        if (eval_noise) evt[1*NC+2] = 1'b1;
        for (int c = 0; c < EVAL-1; c++) @(negedge clk);
        if (mid_chk) check("R10", "quota core2 before judge edge", q_of(2), 128);
        @(negedge clk);
        shared = '0;
        evt    = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) wgt[c*WW +: WW] = WW'(1);
        tgt = 8'd255;
        repeat (3) @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            check("R1", "quota in reset", q_of(k), 128);
            check("R1", "inject in reset", int'(inj[k]), 1);
        end
        rst_n = 1'b1;

        for (int r = 0; r < VEC_N; r++) begin
            run_round(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], TBL[r][5],
                      TBL[r][6], TBL[r][7], 1'b0, r == 0);
            for (int k = 0; k < NC; k++)
                check(row_tag(r), $sformatf("row %0d quota core%0d", r, k), q_of(k), TBL[r][8+k]);
            for (int k = 0; k < NC; k++)
                check("R3", $sformatf("row %0d pulses core%0d", r, k), pc[k], TBL[r][12+k]);
        end

        // R10: events during evaluation cycles are ignored and do not leak forward
        run_round(0,0,0, 0,0,0, 1, 24, 1'b1, 1'b0);
        check("R10", "quota core1 after noisy evaluation", q_of(1), 128);
        check("R10", "quota core2 after noisy evaluation", q_of(2), 32);
        run_round(0,0,0, 0,0,0, 1, 17, 1'b0, 1'b0);
        check("R10", "quota core1 next interval", q_of(1), 128);
        check("R10", "quota core2 next interval", q_of(2), 32);
        check("R10", "quota core3 next interval", q_of(3), 3);

        // R1: reset in the middle of a run restores full rate
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            check("R1", "quota after mid-run reset", q_of(k), 128);
            check("R1", "inject after mid-run reset", int'(inj[k]), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule